// File: doc/BRIEF.md
# Chunked Memory-to-Memory Copy Engine

This block carries out one memory-to-memory copy for a single DMA channel. A start pulse presents a descriptor: a configuration word, a byte count, a destination address and a source address. The engine first screens the descriptor. A zero count finishes at once. A disagreement between the two transfer-size fields ends the job with an error. Any other descriptor is loaded into working ("exec") registers and the copy begins.

The copy moves data in chunks whose size is a power of two and never more than 64 bytes. Each chunk is read into a 64-byte staging buffer and then written out from it. Full chunks go first, and one shorter chunk carries any bytes left over. The exec registers track progress chunk by chunk. A repeat flag in the configuration puts the exec count and addresses back to their starting values when the job ends.

Memory is reached through separate read and write ports. Each port uses a request/acknowledge pair and carries a byte length per beat. Only one access is outstanding at a time.

Top module: `dma_chunk_copier`

## Requirements
- R1: After synchronous reset, busy, run, done and error are low, no read or write request is raised, and all exec outputs are zero.
- R2: A start seen while idle clears done and error and sets run. Busy is high from the next cycle.
- R3: A zero byte count ends the job with done set and run cleared. No memory request is made and the exec outputs are unchanged. This check takes precedence over the size-field check.
- R4: If the write-size field (config bits 27:24) differs from the read-size field (config bits 31:28) on a non-zero count, the job ends with error set and done clear. Run stays set, no memory request is made, and the exec outputs are unchanged.
- R5: Each read and write request carries a length equal to the smaller of the remaining exec count and the chunk size. The chunk size is 2^min(field, 6) bytes, so 64 bytes at most.
- R6: A job that passes both checks copies the descriptor's config, count, destination and source into the exec outputs before the first read request.
- R7: On each chunk's write acknowledge, exec source and exec destination advance by the chunk length and exec count drops by the same amount.
- R8: Every chunk is read, acknowledged, then written from the staging buffer and acknowledged, one access at a time. After the job the destination holds the source bytes, and the byte just past the destination range is untouched.
- R9: With config bit 2 (repeat) set, the exec count, destination and source return to the descriptor values at the end. Without it they end at zero, destination+count and source+count.
- R10: A completed copy sets done, clears run and drops busy in the same cycle.
- R11: A start raised while busy is ignored. This includes a start in the cycle of the final write acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| cfg_i | input | 32 | Descriptor config: read size 31:28, write size 27:24, repeat bit 2 |
| len_i | input | CNT_W | Descriptor byte count |
| dst_i | input | ADDR_W | Descriptor destination address |
| src_i | input | ADDR_W | Descriptor source address |
| busy_o | output | 1 | Job in progress |
| run_o | output | 1 | Run flag |
| done_o | output | 1 | Done status |
| err_o | output | 1 | Error status |
| exec_cfg_o | output | 32 | Exec config |
| exec_len_o | output | CNT_W | Exec remaining count |
| exec_dst_o | output | ADDR_W | Exec destination |
| exec_src_o | output | ADDR_W | Exec source |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_len_o | output | 7 | Read length in bytes |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | 512 | Read data, byte k in bits 8k+7:8k |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | ADDR_W | Write address |
| wr_len_o | output | 7 | Write length in bytes |
| wr_data_o | output | 512 | Write data from staging buffer |
| wr_ack_i | input | 1 | Write acknowledge |

## Verification
Two events can land on the same clock edge: the final write acknowledge, which finishes the job and optionally restores the exec registers, and a new start request. The bench's memory responder raises start together with the last write acknowledge, and in another job together with a mid-job read acknowledge, each time with a different descriptor. The finished job must show its own exec values and status. The engine must then stay idle with no new request.

// File: rtl/dma_copy_pkg.sv
package dma_copy_pkg;

    localparam int MAX_LOG   = 6;
    localparam int LOG_W     = $clog2(MAX_LOG + 1);
    localparam int BUF_BYTES = 1 << MAX_LOG;
    localparam int LEN_W     = MAX_LOG + 1;

    typedef struct packed {
        logic [3:0]  rd_sz;
        logic [3:0]  wr_sz;
        logic [20:0] rsvd_hi;
        logic        rpt;
        logic [1:0]  rsvd_lo;
    } cfg_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_EVAL,
        S_RD,
        S_WR
    } state_t;

    function automatic logic [LOG_W-1:0] cap_log(input logic [3:0] f);
        if (f > 4'(MAX_LOG)) return LOG_W'(MAX_LOG);
        return f[LOG_W-1:0];
    endfunction

endpackage

// File: rtl/dcc_chunk_calc.sv
module dcc_chunk_calc
    import dma_copy_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic [3:0]       size_field,
    input  logic [CNT_W-1:0] remaining,
    output logic [LEN_W-1:0] chunk_len
);
    logic [LOG_W-1:0] lg;
    logic [LEN_W-1:0] csize;

    always_comb begin
        lg    = cap_log(size_field);
        csize = LEN_W'(1) << lg;
        if (remaining >= {{(CNT_W-LEN_W){1'b0}}, csize})
            chunk_len = csize;
        else
            chunk_len = remaining[LEN_W-1:0];
    end
endmodule

// File: rtl/dcc_stage_buf.sv
module dcc_stage_buf
    import dma_copy_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [8*BUF_BYTES-1:0] d,
    output logic [8*BUF_BYTES-1:0] q
);
    for (genvar k = 0; k < BUF_BYTES; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)       q[8*k +: 8] <= '0;
            else if (load) q[8*k +: 8] <= d[8*k +: 8];
        end
    end

    // R8: staging content only changes on a read acknowledge
    p_buf_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));
endmodule

// File: rtl/dma_chunk_copier.sv
module dma_chunk_copier
    import dma_copy_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic [31:0]            cfg_i,
    input  logic [CNT_W-1:0]       len_i,
    input  logic [ADDR_W-1:0]      dst_i,
    input  logic [ADDR_W-1:0]      src_i,
    output logic                   busy_o,
    output logic                   run_o,
    output logic                   done_o,
    output logic                   err_o,
    output logic [31:0]            exec_cfg_o,
    output logic [CNT_W-1:0]       exec_len_o,
    output logic [ADDR_W-1:0]      exec_dst_o,
    output logic [ADDR_W-1:0]      exec_src_o,
    output logic                   rd_req_o,
    output logic [ADDR_W-1:0]      rd_addr_o,
    output logic [LEN_W-1:0]       rd_len_o,
    input  logic                   rd_ack_i,
    input  logic [8*BUF_BYTES-1:0] rd_data_i,
    output logic                   wr_req_o,
    output logic [ADDR_W-1:0]      wr_addr_o,
    output logic [LEN_W-1:0]       wr_len_o,
    output logic [8*BUF_BYTES-1:0] wr_data_o,
    input  logic                   wr_ack_i
);
    state_t            state;
    cfg_t              hold_cfg, exec_cfg;
    logic [CNT_W-1:0]  hold_len, exec_len;
    logic [ADDR_W-1:0] hold_dst, hold_src, exec_dst, exec_src;
    logic              run_q, done_q, err_q;
    logic [LEN_W-1:0]  chunk_len;
    logic [ADDR_W-1:0] chunk_a;
    logic [CNT_W-1:0]  chunk_c;
    logic              mismatch, last_chunk, buf_load;

    dcc_chunk_calc #(.CNT_W(CNT_W)) u_calc (
        .size_field (exec_cfg.wr_sz),
        .remaining  (exec_len),
        .chunk_len  (chunk_len)
    );

    assign buf_load = (state == S_RD) && rd_ack_i;

    dcc_stage_buf u_buf (
        .clk  (clk),
        .rst  (rst),
        .load (buf_load),
        .d    (rd_data_i),
        .q    (wr_data_o)
    );

    assign chunk_a    = {{(ADDR_W-LEN_W){1'b0}}, chunk_len};
    assign chunk_c    = {{(CNT_W-LEN_W){1'b0}}, chunk_len};
    assign mismatch   = hold_cfg.rd_sz != hold_cfg.wr_sz;
    assign last_chunk = chunk_c == exec_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            hold_cfg <= '0;
            hold_len <= '0;
            hold_dst <= '0;
            hold_src <= '0;
            exec_cfg <= '0;
            exec_len <= '0;
            exec_dst <= '0;
            exec_src <= '0;
            run_q    <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start_i) begin
                    hold_cfg <= cfg_t'(cfg_i);
                    hold_len <= len_i;
                    hold_dst <= dst_i;
                    hold_src <= src_i;
                    run_q    <= 1'b1;
                    done_q   <= 1'b0;
                    err_q    <= 1'b0;
                    state    <= S_EVAL;
                end
                S_EVAL: begin
                    if (hold_len == '0) begin
                        done_q <= 1'b1;
                        run_q  <= 1'b0;
                        state  <= S_IDLE;
                    end else if (mismatch) begin
                        err_q  <= 1'b1;
                        state  <= S_IDLE;
                    end else begin
                        exec_cfg <= hold_cfg;
                        exec_len <= hold_len;
                        exec_dst <= hold_dst;
                        exec_src <= hold_src;
                        state    <= S_RD;
                    end
                end
                S_RD: if (rd_ack_i) state <= S_WR;
                S_WR: if (wr_ack_i) begin
                    if (last_chunk) begin
                        if (hold_cfg.rpt) begin
                            exec_len <= hold_len;
                            exec_dst <= hold_dst;
                            exec_src <= hold_src;
                        end else begin
                            exec_len <= '0;
                            exec_dst <= exec_dst + chunk_a;
                            exec_src <= exec_src + chunk_a;
                        end
                        done_q <= 1'b1;
                        run_q  <= 1'b0;
                        state  <= S_IDLE;
                    end else begin
                        exec_len <= exec_len - chunk_c;
                        exec_dst <= exec_dst + chunk_a;
                        exec_src <= exec_src + chunk_a;
                        state    <= S_RD;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy_o     = state != S_IDLE;
    assign run_o      = run_q;
    assign done_o     = done_q;
    assign err_o      = err_q;
    assign exec_cfg_o = exec_cfg;
    assign exec_len_o = exec_len;
    assign exec_dst_o = exec_dst;
    assign exec_src_o = exec_src;
    assign rd_req_o   = state == S_RD;
    assign rd_addr_o  = exec_src;
    assign rd_len_o   = chunk_len;
    assign wr_req_o   = state == S_WR;
    assign wr_addr_o  = exec_dst;
    assign wr_len_o   = chunk_len;

    p_zero_done_r3: assert property (@(posedge clk) disable iff (rst)
        (state == S_EVAL && hold_len == '0) |=>
            (done_o && !run_o && !busy_o && $stable(exec_len_o)));

    p_size_err_r4: assert property (@(posedge clk) disable iff (rst)
        (state == S_EVAL && hold_len != '0 && mismatch) |=>
            (err_o && !done_o && run_o && !busy_o));

    p_req_len_r5: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |-> (rd_len_o != '0 && rd_len_o <= LEN_W'(BUF_BYTES)));

    p_src_adv_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_req_o && wr_ack_i && !(last_chunk && hold_cfg.rpt)) |=>
            (exec_src_o == $past(exec_src_o) + $past(chunk_a)));

    p_one_access_r8: assert property (@(posedge clk) disable iff (rst)
        !(rd_req_o && wr_req_o));

    p_done_run_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> (!run_o && !busy_o));

    p_busy_start_r11: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> (state != S_EVAL));
endmodule

// File: tb/dma_chunk_copier_tb.sv
module dma_chunk_copier_tb;
    localparam int AW = 32;
    localparam int CW = 32;
    localparam int MEMSZ = 2048;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [31:0] cfg_i = '0;
    logic [CW-1:0] len_i = '0;
    logic [AW-1:0] dst_i = '0, src_i = '0;
    logic busy_o, run_o, done_o, err_o;
    logic [31:0] exec_cfg_o;
    logic [CW-1:0] exec_len_o;
    logic [AW-1:0] exec_dst_o, exec_src_o;
    logic rd_req_o, wr_req_o;
    logic [AW-1:0] rd_addr_o, wr_addr_o;
    logic [6:0] rd_len_o, wr_len_o;
    logic rd_ack_i = 1'b0, wr_ack_i = 1'b0;
    logic [511:0] rd_data_i = '0;
    logic [511:0] wr_data_o;

    always #2.5 clk = ~clk;

    dma_chunk_copier u_dut (.*);

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [7:0] mem [MEMSZ];

    int exp_src, exp_dst, exp_rem, exp_chunk, req_seen;
    bit inj_mid, inj_end, resp_start, mid_done;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int min_i(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (resp_start) begin start_i = 1'b0; resp_start = 0; end
            if (rd_ack_i) rd_ack_i = 1'b0;
            else if (rd_req_o && ($urandom % 3 == 0)) begin
                req_seen++;
                chk(rd_addr_o == AW'(exp_src), "R5 read addr", rd_addr_o, exp_src);
                chk(int'(rd_len_o) == min_i(exp_rem, exp_chunk), "R5 read len", rd_len_o, min_i(exp_rem, exp_chunk));
                for (int k = 0; k < 64; k++)
                    rd_data_i[8*k +: 8] = (k < int'(rd_len_o)) ? mem[(int'(rd_addr_o) + k) % MEMSZ] : 8'h00;
                rd_ack_i = 1'b1;
                if (inj_mid && !mid_done) begin
                    mid_done = 1; start_i = 1'b1; resp_start = 1;
                    cfg_i = 32'h1100_0000; len_i = 5; src_i = 3; dst_i = 1900;
                end
            end
            if (wr_ack_i) wr_ack_i = 1'b0;
            else if (wr_req_o && ($urandom % 3 == 0)) begin
                req_seen++;
                chk(wr_addr_o == AW'(exp_dst), "R8 write addr", wr_addr_o, exp_dst);
                chk(int'(wr_len_o) == min_i(exp_rem, exp_chunk), "R5 write len", wr_len_o, min_i(exp_rem, exp_chunk));
                for (int k = 0; k < int'(wr_len_o); k++)
                    mem[(int'(wr_addr_o) + k) % MEMSZ] = wr_data_o[8*k +: 8];
                wr_ack_i = 1'b1;
                if (inj_end && exp_rem == int'(wr_len_o)) begin
                    start_i = 1'b1; resp_start = 1;
                    cfg_i = 32'h3300_0000; len_i = 9; src_i = 7; dst_i = 1950;
                end
                exp_src += int'(wr_len_o);
                exp_dst += int'(wr_len_o);
                exp_rem -= int'(wr_len_o);
            end
        end
    end

    logic [31:0] pv_cfg; int pv_len, pv_dst, pv_src;

    task automatic run_job(input logic [31:0] cfg, input int n, input int dst, input int src, input bit im, input bit ie);
        logic [7:0] snap [];
        logic [7:0] after;
        bit ok;
        int lg, wsz, rsz, cyc;
        wsz = cfg[27:24]; rsz = cfg[31:28];
        lg = (wsz > 6) ? 6 : wsz;
        snap = new[n];
        for (int i = 0; i < n; i++) begin
            mem[src + i] = 8'($urandom);
            snap[i] = mem[src + i];
        end
        after = mem[dst + n];
        exp_src = src; exp_dst = dst; exp_rem = n; exp_chunk = 1 << lg;
        req_seen = 0; inj_mid = im; inj_end = ie; mid_done = 0;
        @(negedge clk);
        cfg_i = cfg; len_i = CW'(n); dst_i = AW'(dst); src_i = AW'(src); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && run_o && !done_o && !err_o, "R2 start state",
            {busy_o, run_o, done_o, err_o}, 4'b1100);
        cyc = 0;
        while (busy_o && cyc < 20000) begin @(negedge clk); cyc++; end
        inj_mid = 0; inj_end = 0;
        if (n == 0) begin
            chk(done_o && !err_o && !run_o, "R3 zero status", {done_o, err_o, run_o}, 3'b100);
            chk(req_seen == 0, "R3 no access", req_seen, 0);
            chk(exec_len_o == CW'(pv_len) && exec_src_o == AW'(pv_src) && exec_dst_o == AW'(pv_dst),
                "R3 exec unchanged", exec_len_o, pv_len);
        end else if (wsz != rsz) begin
            chk(err_o && !done_o && run_o, "R4 mismatch status", {done_o, err_o, run_o}, 3'b011);
            chk(req_seen == 0, "R4 no access", req_seen, 0);
            chk(exec_len_o == CW'(pv_len) && exec_src_o == AW'(pv_src) && exec_dst_o == AW'(pv_dst)
                && exec_cfg_o == pv_cfg, "R4 exec unchanged", exec_src_o, pv_src);
        end else begin
            chk(done_o && !err_o && !run_o && !busy_o, "R10 completion", {done_o, err_o, run_o}, 3'b100);
            chk(exec_cfg_o == cfg, "R6 exec cfg", exec_cfg_o, cfg);
            if (cfg[2]) begin
                chk(exec_len_o == CW'(n) && exec_src_o == AW'(src) && exec_dst_o == AW'(dst),
                    "R9 repeat restore", exec_src_o, src);
                pv_len = n; pv_src = src; pv_dst = dst;
            end else begin
                chk(exec_len_o == 0 && exec_src_o == AW'(src + n) && exec_dst_o == AW'(dst + n),
                    "R7 final exec", exec_dst_o, dst + n);
                pv_len = 0; pv_src = src + n; pv_dst = dst + n;
            end
            pv_cfg = cfg;
            chk(exp_rem == 0, "R5 bytes covered", exp_rem, 0);
            ok = 1;
            for (int i = 0; i < n; i++) if (mem[dst + i] != snap[i]) ok = 0;
            chk(ok, "R8 data copy", ok, 1);
            chk(mem[dst + n] == after, "R8 no overrun", mem[dst + n], after);
        end
        if (ie || im) begin
            repeat (3) @(negedge clk);
            chk(!busy_o && !rd_req_o && !wr_req_o, "R11 start ignored", busy_o, 0);
            chk(exec_dst_o == AW'(pv_dst), "R11 exec kept", exec_dst_o, pv_dst);
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < MEMSZ; i++) mem[i] = 8'h00;
        pv_cfg = '0; pv_len = 0; pv_dst = 0; pv_src = 0;
        repeat (3) @(negedge clk);
        chk(!busy_o && !run_o && !done_o && !err_o && !rd_req_o && !wr_req_o, "R1 reset status",
            {busy_o, run_o, done_o, err_o}, 0);
        chk(exec_cfg_o == 0 && exec_len_o == 0 && exec_src_o == 0 && exec_dst_o == 0,
            "R1 reset exec", exec_src_o, 0);
        rst = 1'b0;
        // directed corners
        run_job(32'h6600_0000, 200, 1100, 10, 0, 0);  // 64-byte chunks + remainder
        run_job(32'h1200_0000, 0,   1200, 20, 0, 0);  // zero with mismatch: R3 wins
        run_job(32'h2300_0000, 40,  1300, 30, 0, 0);  // mismatch
        run_job(32'h9900_0004, 130, 1024, 50, 0, 0);  // capped size, repeat
        run_job(32'h0000_0000, 7,   1500, 60, 0, 0);  // 1-byte chunks
        run_job(32'h3300_0000, 8,   1600, 70, 0, 0);  // exact single chunk
        run_job(32'h4400_0000, 45,  1100, 80, 1, 0);  // start mid-job
        run_job(32'h5500_0004, 77,  1200, 90, 0, 1);  // start on final ack, repeat
        run_job(32'h2200_0000, 3,   1300, 100, 0, 1); // remainder only, start on final ack
        for (int j = 0; j < 16; j++) begin
            logic [3:0] a, b;
            logic [31:0] c;
            a = 4'($urandom % 9);
            b = ($urandom % 5 == 0) ? 4'($urandom % 9) : a;
            c = {b, a, 21'd0, 1'($urandom), 2'd0};
            run_job(c, $urandom % 301, 1024 + $urandom % 600, $urandom % 700, 0, 0);
        end
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog timeout actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule